// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a three-level translation tree that is kept in ordinary memory. The address is cut into an 8-bit top index, a 6-bit middle index, a 6-bit bottom index and a 12-bit byte offset. Each index picks one 32-bit word in a 4 KB table at its level. The walk starts at the frame named by a root-table register. Software reloads that register when the address space changes, for example on a context switch.

A request carries an access kind: read, write or execute. The walker reads one table word per level over a single-outstanding request/acknowledge memory port. It checks the final entry's access rights and then returns the frame number with the unchanged offset appended, together with the page's rights and its no-cache flag. If the walk cannot complete, it reports a fault code and the level where the walk stopped. On success the walker sets the used bit in the final entry, and also the dirty bit on a write. It writes the entry back only when one of those bits actually changes.

Entry layout, which the walker decodes:
- bit 0: present
- bit 1: read right
- bit 2: write right
- bit 3: execute right
- bit 4: used
- bit 5: dirty
- bit 6: no-cache
- bits 31:12: next-table frame or page frame

Top module: `pgw_walker`

## Requirements
- R1: Table indices are va[31:24] at level 1, va[23:18] at level 2 and va[17:12] at level 3. The entry read at a level is at byte address {table frame, 12'h000} + 4*index.
- R2: ptbr_load captures ptbr_value as the root frame. A walk uses the root value held in the cycle it was accepted, even if the register is reloaded while the walk runs.
- R3: At level 1 or 2, an entry with bit 0 set and bits 3:1 all zero is a pointer. Its bits 31:12 become the table frame for the next level.
- R4: A successful walk raises done for exactly one cycle. At the same time it gives res_paddr = {entry[31:12], va[11:0]}, res_rwx = entry[3:1] and res_nocache = entry[6]. done and fault are never high together.
- R5: An entry with bit 0 clear stops the walk with fault_code 1 (absent) and fault_level set to that level (1, 2 or 3). fault stays high for exactly one cycle and done does not rise.
- R6: req_acc 0 (read) needs bit 1, 1 (write) needs bit 2 and 2 (execute) needs bit 3 of the level-3 entry. req_acc 3 is never allowed. A refused access gives fault_code 2 at level 3.
- R7: An entry that is malformed gives fault_code 3 at its level. That covers a present level-1 or level-2 entry with any of bits 3:1 set, and a present level-3 entry with bits 3:1 all zero. This check takes precedence over the rights check.
- R8: After a permitted access, the level-3 entry is written back to the address it was read from, with bit 4 set and, on a write, bit 5 set. The write happens only when that changes the word. A walk that faults writes nothing.
- R9: req_ready is high only while the walker is idle. A request is taken only when req_valid and req_ready are both high. A request raised during a walk is ignored.
- R10: mem_req stays high with a stable mem_addr and mem_we until the cycle mem_ack is sampled high. A level reads memory exactly once, so a walk that stops at level k makes k reads.
- R11: After reset the walker is idle: req_ready is high and mem_req, done and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_load | input | 1 | Load the root-table frame register |
| ptbr_value | input | 20 | New root-table frame number |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the table word |
| mem_wdata | output | 32 | Entry written back |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | One-cycle pulse: translation result valid |
| res_paddr | output | 32 | Physical address |
| res_rwx | output | 3 | Rights of the page (read, write, execute) |
| res_nocache | output | 1 | Page must not be cached |
| fault | output | 1 | One-cycle pulse: walk failed |
| fault_code | output | 2 | 1 absent, 2 rights refused, 3 malformed entry |
| fault_level | output | 2 | Level (1 to 3) where the walk stopped |

## Verification
The assertions assume a memory that acknowledges only while mem_req is high and pulses mem_ack for one cycle per access, with read data valid in that cycle. The bench model answers only a pending request, after a delay of zero to two cycles. It drops the acknowledge right after the walker has taken it, so a held request is never answered twice. Requests are offered only while req_ready is high, except in the one case that tests a request made during a walk, which lasts one cycle and is withdrawn before the walker returns to idle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // entry bit positions decoded by the walker
  localparam int E_V   = 0;
  localparam int E_R   = 1;
  localparam int E_W   = 2;
  localparam int E_X   = 3;
  localparam int E_REF = 4;
  localparam int E_MOD = 5;
  localparam int E_NC  = 6;

  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_EXEC, ACC_RSVD} acc_e;
  typedef enum logic [1:0] {FLT_NONE, FLT_ABSENT, FLT_PROT, FLT_BAD} flt_e;
  typedef enum logic [2:0] {S_IDLE, S_LV1, S_LV2, S_LV3, S_WB, S_DONE, S_FLT} walk_e;

  // whether an access kind is covered by the three rights bits (r,w,x)
  function automatic logic acc_allowed(input acc_e acc, input logic [2:0] rwx);
    case (acc)
      ACC_READ:  return rwx[0];
      ACC_WRITE: return rwx[1];
      ACC_EXEC:  return rwx[2];
      default:   return 1'b0;
    endcase
  endfunction

  // status bits an access leaves in the entry
  function automatic logic [31:0] mark_entry(input logic [31:0] ent, input acc_e acc);
    logic [31:0] m;
    m = ent;
    m[E_REF] = 1'b1;
    if (acc == ACC_WRITE) m[E_MOD] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pgw_index.sv
module pgw_index #(
  parameter int L1_BITS  = 8,
  parameter int L2_BITS  = 6,
  parameter int L3_BITS  = 6,
  parameter int OFF_BITS = 12
) (
  input  logic [L1_BITS+L2_BITS+L3_BITS-1:0] vpn,
  input  logic [1:0]                         lvl,
  input  logic [31-OFF_BITS:0]               tbl_pfn,
  output logic [31:0]                        ent_addr
);
  localparam int VPN_BITS = L1_BITS + L2_BITS + L3_BITS;

  logic [OFF_BITS-1:0] idx;

  always_comb begin
    case (lvl)
      2'd1:    idx = OFF_BITS'(vpn[VPN_BITS-1 -: L1_BITS]);
      2'd2:    idx = OFF_BITS'(vpn[L3_BITS +: L2_BITS]);
      2'd3:    idx = OFF_BITS'(vpn[0 +: L3_BITS]);
      default: idx = '0;
    endcase
  end

  assign ent_addr = {tbl_pfn, {OFF_BITS{1'b0}}} + 32'({idx, 2'b00});

endmodule

// File: rtl/pgw_check.sv
module pgw_check
  import pgw_pkg::*;
(
  input  logic [31:0] ent,
  input  logic [1:0]  lvl,
  input  acc_e        acc,
  output flt_e        flt,
  output logic        is_ptr,
  output logic [31:0] upd_ent,
  output logic        upd_needed
);
  logic [2:0] rwx;
  assign rwx = ent[E_X:E_R];

  always_comb begin
    flt    = FLT_NONE;
    is_ptr = 1'b0;
    if (!ent[E_V])                 flt = FLT_ABSENT;
    else if (lvl != 2'd3) begin
      if (rwx != 3'b000)           flt = FLT_BAD;
      else                         is_ptr = 1'b1;
    end
    else if (rwx == 3'b000)        flt = FLT_BAD;
    else if (!acc_allowed(acc, rwx)) flt = FLT_PROT;
  end

  assign upd_ent    = mark_entry(ent, acc);
  assign upd_needed = (upd_ent != ent);

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int L1_BITS  = 8,
  parameter int L2_BITS  = 6,
  parameter int L3_BITS  = 6,
  parameter int OFF_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptbr_load,
  input  logic [19:0] ptbr_value,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  output logic        req_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] res_paddr,
  output logic [2:0]  res_rwx,
  output logic        res_nocache,
  output logic        fault,
  output logic [1:0]  fault_code,
  output logic [1:0]  fault_level
);
  localparam int VPN_BITS = L1_BITS + L2_BITS + L3_BITS;
  localparam int PFN_BITS = 32 - OFF_BITS;

  walk_e               state;
  logic [PFN_BITS-1:0] root_q, tbl_q;
  logic [31:0]         va_q, wb_q, paddr_q;
  acc_e                acc_q;
  logic [2:0]          rwx_q;
  logic                nc_q;
  flt_e                flt_q;
  logic [1:0]          flvl_q;

  // named internal events
  logic [1:0]  cur_lvl;
  logic        accept;
  logic        rd_ack;
  flt_e        chk_flt;
  logic        chk_ptr;
  logic [31:0] chk_upd;
  logic        chk_upd_needed;

  always_comb begin
    case (state)
      S_LV1:       cur_lvl = 2'd1;
      S_LV2:       cur_lvl = 2'd2;
      S_LV3, S_WB: cur_lvl = 2'd3;
      default:     cur_lvl = 2'd0;
    endcase
  end

  assign accept = req_valid && (state == S_IDLE);
  assign rd_ack = mem_ack && (state inside {S_LV1, S_LV2, S_LV3});

  pgw_index #(
    .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS), .OFF_BITS(OFF_BITS)
  ) u_index (
    .vpn     (va_q[31 -: VPN_BITS]),
    .lvl     (cur_lvl),
    .tbl_pfn (tbl_q),
    .ent_addr(mem_addr)
  );

  pgw_check u_check (
    .ent       (mem_rdata),
    .lvl       (cur_lvl),
    .acc       (acc_q),
    .flt       (chk_flt),
    .is_ptr    (chk_ptr),
    .upd_ent   (chk_upd),
    .upd_needed(chk_upd_needed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      root_q  <= '0;
      tbl_q   <= '0;
      va_q    <= '0;
      acc_q   <= ACC_READ;
      wb_q    <= '0;
      paddr_q <= '0;
      rwx_q   <= '0;
      nc_q    <= 1'b0;
      flt_q   <= FLT_NONE;
      flvl_q  <= '0;
    end else begin
      if (ptbr_load) root_q <= ptbr_value;
      case (state)
        S_IDLE: if (accept) begin
          va_q  <= req_vaddr;
          acc_q <= acc_e'(req_acc);
          tbl_q <= root_q;
          state <= S_LV1;
        end
        S_LV1, S_LV2, S_LV3: if (mem_ack) begin
          if (chk_flt != FLT_NONE) begin
            flt_q  <= chk_flt;
            flvl_q <= cur_lvl;
            state  <= S_FLT;
          end else if (chk_ptr) begin
            tbl_q <= mem_rdata[31 -: PFN_BITS];
            state <= (state == S_LV1) ? S_LV2 : S_LV3;
          end else begin
            paddr_q <= {mem_rdata[31 -: PFN_BITS], va_q[OFF_BITS-1:0]};
            rwx_q   <= mem_rdata[E_X:E_R];
            nc_q    <= mem_rdata[E_NC];
            wb_q    <= chk_upd;
            state   <= chk_upd_needed ? S_WB : S_DONE;
          end
        end
        S_WB:    if (mem_ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign mem_req     = (state inside {S_LV1, S_LV2, S_LV3, S_WB});
  assign mem_we      = (state == S_WB);
  assign mem_wdata   = wb_q;
  assign done        = (state == S_DONE);
  assign fault       = (state == S_FLT);
  assign res_paddr   = paddr_q;
  assign res_rwx     = rwx_q;
  assign res_nocache = nc_q;
  assign fault_code  = flt_q;
  assign fault_level = flvl_q;

  // ---------------- assertions ----------------
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  p_accept_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req && !mem_we);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  p_done_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault && req_ready);

  p_fault_coded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code != 2'd0) && (fault_level != 2'd0));

  p_wb_marks_used_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[E_REF] && mem_wdata[E_V]);

  p_ptr_next_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && chk_ptr |=> mem_req && !mem_we && (mem_addr[31:OFF_BITS] == $past(mem_rdata[31:OFF_BITS])));

endmodule

// File: tb/test_pgw_walker.sv
module test_pgw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptbr_load = 1'b0;
  logic [19:0] ptbr_value = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, res_nocache, fault;
  logic [31:0] res_paddr;
  logic [2:0]  res_rwx;
  logic [1:0]  fault_code, fault_level;

  always #5 clk = ~clk;

  pgw_walker i_pgw_walker (
    .clk(clk), .rst_n(rst_n), .ptbr_load(ptbr_load), .ptbr_value(ptbr_value),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_ready(req_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .res_paddr(res_paddr),
    .res_rwx(res_rwx), .res_nocache(res_nocache), .fault(fault),
    .fault_code(fault_code), .fault_level(fault_level)
  );

  // 16 KB word memory: four 4 KB frames
  logic [31:0] mem [4096];
  int rd_cnt = 0, wr_cnt = 0, lat = 0, wait_cnt = 0;
  int checks = 0, fails = 0;
  logic finished = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && rst_n) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr[13:2]] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem[mem_addr[13:2]];
            rd_cnt++;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int widx(input int frame, input int idx);
    return frame * 1024 + idx;
  endfunction

  task automatic start(input [31:0] va, input [1:0] acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // waits for the end pulse; returns sampled results
  logic        g_done, g_fault;
  logic [31:0] g_paddr;
  logic [2:0]  g_rwx;
  logic        g_nc;
  logic [1:0]  g_code, g_lvl;

  task automatic finish_walk(input string req);
    int n = 0;
    while (!(done || fault) && n < 200) begin @(negedge clk); n++; end
    g_done = done; g_fault = fault; g_paddr = res_paddr; g_rwx = res_rwx;
    g_nc = res_nocache; g_code = fault_code; g_lvl = fault_level;
    if (n >= 200) chk(1'b0, {req, " walk ended"}, 0, 1);
    @(negedge clk);
    chk(!done && !fault, "R4/R5 pulse one cycle", {30'd0, done, fault}, 0);
  endtask

  // check a faulting walk
  task automatic expect_fault(input [1:0] code, input [1:0] lvl, input string req);
    chk(g_fault && !g_done, req, {30'd0, g_done, g_fault}, 32'd1);
    chk(g_code == code, req, g_code, code);
    chk(g_lvl == lvl, req, g_lvl, lvl);
    chk(rd_cnt == lvl, "R10 reads per level", rd_cnt, lvl);
    chk(wr_cnt == 0, "R8 no write on fault", wr_cnt, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready && !mem_req && !done && !fault, "R11 reset idle",
        {28'd0, req_ready, mem_req, done, fault}, 32'h8);

    // root frame 0, level-2 table frame 1, level-3 table frame 2
    for (int n = 0; n < 256; n++) begin
      int acc = n / 64;
      int rwx = (n / 8) % 8;
      int rm = (n / 2) % 4;
      int cd = n % 2;
      int i1 = (n * 37 + 3) % 256;
      int i2 = (n * 11 + 1) % 64;
      int i3 = (n * 5 + 7) % 64;
      int off = (n * 123) % 4096;
      logic [19:0] pfn;
      logic [31:0] e3, e3n, va;
      bit perm;
      lat = n % 3;
      pfn = 20'((n * 769 + 5) % 1048576);
      e3 = {pfn, 12'd0} | 32'(cd << 6) | 32'(rm << 4) | 32'(rwx << 1) | 32'd1;
      mem[widx(0, i1)] = 32'h0000_1001;
      mem[widx(1, i2)] = 32'h0000_2001;
      mem[widx(2, i3)] = e3;
      va = {i1[7:0], i2[5:0], i3[5:0], off[11:0]};
      start(va, acc[1:0]);
      finish_walk("R1 leaf sweep");
      perm = (acc == 0) ? rwx[0] : (acc == 1) ? rwx[1] : (acc == 2) ? rwx[2] : 1'b0;
      if (rwx == 0) expect_fault(2'd3, 2'd3, "R7 level3 no rights");
      else if (!perm) expect_fault(2'd2, 2'd3, "R6 refused access");
      else begin
        e3n = e3 | 32'h10 | ((acc == 1) ? 32'h20 : 32'h0);
        chk(g_done && !g_fault, "R4 done", {30'd0, g_done, g_fault}, 32'd2);
        chk(g_paddr == {pfn, off[11:0]}, "R4 paddr via R1 R3 indices", g_paddr, {pfn, off[11:0]});
        chk(g_nc == cd[0], "R4 nocache", {31'd0, g_nc}, cd);
        chk(g_rwx == rwx[2:0], "R4 rights", {29'd0, g_rwx}, rwx);
        chk(mem[widx(2, i3)] == e3n, "R8 status bits", mem[widx(2, i3)], e3n);
        chk(wr_cnt == ((e3n != e3) ? 1 : 0), "R8 write only on change", wr_cnt, (e3n != e3) ? 1 : 0);
        chk(rd_cnt == 3, "R10 three reads", rd_cnt, 3);
      end
      mem[widx(0, i1)] = '0; mem[widx(1, i2)] = '0; mem[widx(2, i3)] = '0;
    end

    // R5 absent at every level, R7 malformed at levels 1 and 2
    for (int lv = 1; lv <= 3; lv++) begin
      for (int kind = 0; kind < 2; kind++) begin
        logic [31:0] bad;
        if (kind == 1 && lv == 3) continue;
        bad = (kind == 0) ? 32'h0000_307E : 32'h0000_1005;
        lat = lv - 1;
        mem[widx(0, 9)]  = (lv == 1) ? bad : 32'h0000_1001;
        mem[widx(1, 4)]  = (lv == 2) ? bad : 32'h0000_2001;
        mem[widx(2, 60)] = (lv == 3) ? bad : 32'h0001_2343;
        start({8'd9, 6'd4, 6'd60, 12'h0AB}, 2'd0);
        finish_walk("R5 R7 faults");
        if (kind == 0) expect_fault(2'd1, lv[1:0], "R5 absent entry");
        else expect_fault(2'd3, lv[1:0], "R7 leaf above level 3");
        mem[widx(0, 9)] = '0; mem[widx(1, 4)] = '0; mem[widx(2, 60)] = '0;
      end
    end

    // R2: root reload, and reload during a walk
    mem[widx(0, 200)] = 32'h0000_1001;
    mem[widx(1, 33)]  = 32'h0000_2001;
    mem[widx(2, 17)]  = 32'hABCD_E013;
    lat = 0;
    @(negedge clk); ptbr_value = 20'd3; ptbr_load = 1'b1;
    @(negedge clk); ptbr_load = 1'b0;
    start({8'd200, 6'd33, 6'd17, 12'h555}, 2'd0);
    finish_walk("R2 root reload");
    expect_fault(2'd1, 2'd1, "R2 empty root after reload");
    lat = 2;
    @(negedge clk); ptbr_value = 20'd0; ptbr_load = 1'b1;
    @(negedge clk); ptbr_load = 1'b0;
    start({8'd200, 6'd33, 6'd17, 12'h555}, 2'd0);
    ptbr_value = 20'd3; ptbr_load = 1'b1;
    @(negedge clk); ptbr_load = 1'b0;
    finish_walk("R2 reload mid walk");
    chk(g_done && g_paddr == 32'hABCD_E555, "R2 walk keeps accepted root", g_paddr, 32'hABCD_E555);
    @(negedge clk); ptbr_value = 20'd0; ptbr_load = 1'b1;
    @(negedge clk); ptbr_load = 1'b0;

    // R9: request during a walk is ignored
    lat = 1;
    start({8'd200, 6'd33, 6'd17, 12'h001}, 2'd0);
    @(negedge clk);
    chk(!req_ready, "R9 busy not ready", {31'd0, req_ready}, 0);
    req_valid = 1'b1; req_vaddr = 32'h0000_0000; req_acc = 2'd1;
    @(negedge clk); req_valid = 1'b0;
    finish_walk("R9 busy request");
    chk(g_done && g_paddr == 32'hABCD_E001, "R9 first walk intact", g_paddr, 32'hABCD_E001);
    chk(rd_cnt == 3 && wr_cnt == 0, "R9 no extra access", rd_cnt * 16 + wr_cnt, 48);
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (mem_req || !req_ready) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R9 stays idle after ignored request", {31'd0, quiet}, 1);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule